// File: doc/BRIEF.md
# Quad DAC Double-Buffered Bus Interface

This block is the digital control logic for a four-channel, 14-bit digital-to-analog converter that is loaded over a parallel bus. Each channel has two stages of storage. An input register takes data from the bus. A DAC latch holds the code that drives the converter. A host can fill any input register, or all four at once, without disturbing the converter outputs. It can then move every channel to its new code together with one load strobe. If the load strobe is held low, each write passes straight through to the addressed latch at the end of the write strobe.

Full 14-bit words can be written in one access. Where the bus is only eight bits wide, the byte-shift control moves the low bus lines into the upper field of the register, so a word takes two accesses. A clear input acts at once, without waiting for the clock, and puts every output into sense-ground mode. The first channel pair uses ground A and the second pair uses ground B. The outputs stay in that mode after clear is released, until the load strobe is next brought low. All other inputs pass through a two-stage synchronizer on the system clock.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After reset, all four `code_o` fields are 0 and every `mode_o` field shows sense ground. The field encoding is DAC=0, ground A=1, ground B=2. Channel i occupies `mode_o[2i+1:2i]` and `code_o[14i+13:14i]`.
- R2: A write with `byte_full`=1 loads all 14 bits of `data` into the addressed input register.
- R3: A write with `byte_full`=0 places `data[5:0]` into bits 13:8 of the addressed input register. Bits 7:0 of that register are left unchanged.
- R4: When `bcast`=0, the value k on `addr` picks channel k (0..3). Only that channel's register is written.
- R5: With `bcast`=1 a write goes to all four channels, whatever `addr` holds.
- R6: A write takes place only while `cs_n` and `wr_n` are both low. Holding `wr_n` low while `cs_n` is high changes nothing.
- R7: While `ld_n` is high, writes leave every `code_o` field unchanged.
- R8: A high-to-low change of `ld_n`, with clear inactive, copies all four input registers into the DAC latches in the same cycle.
- R9: If `ld_n` is already low when `wr_n` rises to end a write, the addressed latch (or all four under broadcast) takes the new code. The other latches keep their codes.
- R10: A low `clr_n` forces channels 0 and 1 to ground A and channels 2 and 3 to ground B. This happens without waiting for a clock edge.
- R11: While clear is low, `ld_n` is ignored. No falling edge of `ld_n` and no write-through alters any latch.
- R12: After `clr_n` returns high the outputs stay in sense-ground mode until the next falling `ld_n`. That edge loads the latches and switches every channel to DAC mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Channel number |
| bcast | input | 1 | 1 = write all channels |
| byte_full | input | 1 | 1 = full word, 0 = low byte into upper field |
| data | input | 14 | Data bus, bit 13 is the MSB |
| ld_n | input | 1 | Load strobe, level sensitive, active low |
| clr_n | input | 1 | Clear, asynchronous, active low |
| code_o | output | 56 | Four 14-bit DAC latch codes, channel 0 in the low bits |
| mode_o | output | 8 | Four 2-bit output modes |

## Verification
Every clocked effect lands on the third rising edge after the bench drives an input. Two edges are spent in the synchronizer and one in the register that acts. The one exception is the clear override, which appears on `mode_o` within the same clock period. The bench changes inputs on falling edges and holds each strobe for several cycles. It reads results only five or more cycles after the last change, so every check falls well after the edge that produced it. Clear is checked one nanosecond after `clr_n` falls, before any clock edge, which shows the override is asynchronous.

The write controller has two states. W_IDLE moves to W_ACTIVE when select and strobe are both low. W_ACTIVE returns to W_IDLE in one of two ways: on a strobe rise, which commits the write, or on a select rise, which aborts it. The output controller also has two states. OM_GROUND moves to OM_DRIVE on a falling load edge while clear is high. OM_DRIVE returns to OM_GROUND when the synchronized clear goes low.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    typedef enum logic [1:0] {
        OUT_DAC = 2'd0,
        OUT_SGA = 2'd1,
        OUT_SGB = 2'd2
    } out_mode_e;

    typedef enum logic {
        W_IDLE   = 1'b0,
        W_ACTIVE = 1'b1
    } wr_state_e;

    typedef enum logic {
        OM_GROUND = 1'b0,
        OM_DRIVE  = 1'b1
    } om_state_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= RST_VAL;
                end else if (s == 0) begin
                    stage_q[s] <= d;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/qdac_wr_fsm.sv
module qdac_wr_fsm
    import qdac_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n_s,
    input  logic           wr_n_s,
    input  logic [AW-1:0]  addr_s,
    input  logic           bcast_s,
    output logic           wen,
    output logic [NCH-1:0] wmask,
    output logic           commit,
    output logic [NCH-1:0] lat_mask
);

    wr_state_e      state_q, state_d;
    logic [NCH-1:0] mask_q;
    logic           sel;

    assign sel = !cs_n_s && !wr_n_s;

    always_comb begin
        wmask = '0;
        if (bcast_s) begin
            wmask = '1;
        end else begin
            for (int i = 0; i < NCH; i++) begin
                wmask[i] = (addr_s == AW'(i));
            end
        end
    end

    // state register and captured target mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (sel) begin
                mask_q <= wmask;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            W_IDLE:   if (sel) state_d = W_ACTIVE;
            W_ACTIVE: if (wr_n_s || cs_n_s) state_d = W_IDLE;
            default:  state_d = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wen      = sel;
        commit   = 1'b0;
        lat_mask = mask_q;
        unique case (state_q)
            W_IDLE:   commit = 1'b0;
            W_ACTIVE: commit = wr_n_s;
            default:  commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/qdac_chan_bank.sv
module qdac_chan_bank #(
    parameter int NCH  = 4,
    parameter int DW   = 14,
    parameter int LO_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wen,
    input  logic [NCH-1:0]    wmask,
    input  logic              byte_full,
    input  logic [DW-1:0]     data,
    input  logic              xfer_all,
    input  logic              wt_en,
    input  logic [NCH-1:0]    wt_mask,
    output logic [NCH*DW-1:0] code_o
);

    localparam int HI_W = DW - LO_W;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_ch
            logic [DW-1:0] in_q;
            logic [DW-1:0] lat_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    in_q <= '0;
                end else if (wen && wmask[i]) begin
                    if (byte_full) begin
                        in_q <= data;
                    end else begin
                        in_q[DW-1:LO_W] <= data[HI_W-1:0];
                    end
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lat_q <= '0;
                end else if (xfer_all || (wt_en && wt_mask[i])) begin
                    lat_q <= in_q;
                end
            end

            assign code_o[i*DW +: DW] = lat_q;
        end
    endgenerate

endmodule

// File: rtl/qdac_out_fsm.sv
module qdac_out_fsm
    import qdac_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_n_raw,
    input  logic             clr_s,
    input  logic             ld_s,
    output logic             xfer_all,
    output logic [2*NCH-1:0] mode_o
);

    localparam int HALF = NCH / 2;

    om_state_e state_q, state_d;
    logic      ld_prev_q;
    logic      grounded;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= OM_GROUND;
            ld_prev_q <= 1'b1;
        end else begin
            state_q   <= state_d;
            ld_prev_q <= ld_s;
        end
    end

    assign xfer_all = ld_prev_q && !ld_s && clr_s;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OM_GROUND: if (xfer_all) state_d = OM_DRIVE;
            OM_DRIVE:  if (!clr_s)   state_d = OM_GROUND;
            default:   state_d = OM_GROUND;
        endcase
    end

    // outputs: raw clear overrides without waiting for a clock
    always_comb begin
        unique case (state_q)
            OM_GROUND: grounded = 1'b1;
            OM_DRIVE:  grounded = !clr_n_raw;
            default:   grounded = 1'b1;
        endcase
    end

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_mode
            localparam out_mode_e GRP = (i < HALF) ? OUT_SGA : OUT_SGB;
            assign mode_o[2*i +: 2] = grounded ? GRP : OUT_DAC;
        end
    endgenerate

endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
    parameter int NCH    = 4,
    parameter int DW     = 14,
    parameter int AW     = 2,
    parameter int STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_n,
    input  logic [AW-1:0]     addr,
    input  logic              bcast,
    input  logic              byte_full,
    input  logic [DW-1:0]     data,
    input  logic              ld_n,
    input  logic              clr_n,
    output logic [NCH*DW-1:0] code_o,
    output logic [2*NCH-1:0]  mode_o
);

    localparam int SW = AW + DW + 6;
    localparam logic [SW-1:0] SYNC_RST =
        {1'b1, 1'b1, {AW{1'b0}}, 1'b0, 1'b1, {DW{1'b0}}, 1'b1, 1'b0};

    logic [SW-1:0]  raw_v, syn_v;
    logic           cs_n_s, wr_n_s, bcast_s, byte_s, ld_s, clr_s;
    logic [AW-1:0]  addr_s;
    logic [DW-1:0]  data_s;
    logic           wen, commit, xfer_all, wt_en;
    logic [NCH-1:0] wmask, lat_mask;

    assign raw_v = {cs_n, wr_n, addr, bcast, byte_full, data, ld_n, clr_n};

    qdac_sync #(.W(SW), .STAGES(STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_v),
        .q     (syn_v)
    );

    assign {cs_n_s, wr_n_s, addr_s, bcast_s, byte_s, data_s, ld_s, clr_s} = syn_v;

    qdac_wr_fsm #(.NCH(NCH), .AW(AW)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (cs_n_s),
        .wr_n_s   (wr_n_s),
        .addr_s   (addr_s),
        .bcast_s  (bcast_s),
        .wen      (wen),
        .wmask    (wmask),
        .commit   (commit),
        .lat_mask (lat_mask)
    );

    qdac_out_fsm #(.NCH(NCH)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_n_raw (clr_n),
        .clr_s     (clr_s),
        .ld_s      (ld_s),
        .xfer_all  (xfer_all),
        .mode_o    (mode_o)
    );

    assign wt_en = commit && !ld_s && clr_s;

    qdac_chan_bank #(.NCH(NCH), .DW(DW), .LO_W(8)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wen       (wen),
        .wmask     (wmask),
        .byte_full (byte_s),
        .data      (data_s),
        .xfer_all  (xfer_all),
        .wt_en     (wt_en),
        .wt_mask   (lat_mask),
        .code_o    (code_o)
    );

endmodule

// File: rtl/qdac_chk.sv
module qdac_chk #(
    parameter int NCH = 4,
    parameter int DW  = 14
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr_n,
    input logic              clr_s,
    input logic              xfer_all,
    input logic              wt_en,
    input logic              commit,
    input logic [NCH-1:0]    lat_mask,
    input logic [NCH*DW-1:0] code_o,
    input logic [2*NCH-1:0]  mode_o
);

    logic [2*NCH-1:0] gnd_pat;

    always_comb begin
        for (int i = 0; i < NCH; i++) begin
            gnd_pat[2*i +: 2] = (i < NCH/2) ? 2'd1 : 2'd2;
        end
    end

    p_clr_forces_gnd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (mode_o == gnd_pat));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_all && !wt_en) |=> $stable(code_o));

    p_clr_blocks_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_s |=> $stable(code_o));

    p_gnd_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == gnd_pat && clr_n && !xfer_all) |=> (mode_o == gnd_pat));

    p_commit_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ($countones(lat_mask) == 1 || lat_mask == '1));

endmodule

bind quad_dac_ctrl qdac_chk #(.NCH(NCH), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_n    (clr_n),
    .clr_s    (clr_s),
    .xfer_all (xfer_all),
    .wt_en    (wt_en),
    .commit   (commit),
    .lat_mask (lat_mask),
    .code_o   (code_o),
    .mode_o   (mode_o)
);

// File: tb/sim_quad_dac_ctrl.sv
module sim_quad_dac_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, bcast = 1'b0, byte_full = 1'b1;
    logic        ld_n = 1'b1, clr_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [13:0] data = '0;
    logic [55:0] code_o;
    logic [7:0]  mode_o;

    logic [13:0] exp_in  [4];
    logic [13:0] exp_lat [4];
    logic        exp_gnd;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    quad_dac_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .bcast(bcast), .byte_full(byte_full), .data(data), .ld_n(ld_n),
        .clr_n(clr_n), .code_o(code_o), .mode_o(mode_o)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    function automatic logic [7:0] exp_mode();
        logic [7:0] m;
        for (int i = 0; i < 4; i++) m[2*i +: 2] = exp_gnd ? ((i < 2) ? 2'd1 : 2'd2) : 2'd0;
        return m;
    endfunction

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_codes(input string tag);
        for (int c = 0; c < 4; c++) chk(tag, 64'(code_o[c*14 +: 14]), 64'(exp_lat[c]));
    endtask

    // one bus write; updates the model (R2..R6, R9)
    task automatic bus_wr(input int ch, input bit all, input bit full,
                          input logic [13:0] d, input bit sel_ok);
        addr = 2'(ch); bcast = all; byte_full = full; data = d;
        cs_n = sel_ok ? 1'b0 : 1'b1;
        wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(1);
        cs_n = 1'b1;
        wait_n(6);
        if (sel_ok) begin
            for (int c = 0; c < 4; c++) begin
                if (all || c == ch) begin
                    if (full) exp_in[c] = d;
                    else      exp_in[c][13:8] = d[5:0];
                    if (!ld_n && clr_n) exp_lat[c] = exp_in[c];
                end
            end
        end
    endtask

    task automatic ld_fall();
        ld_n = 1'b0;
        wait_n(6);
        if (clr_n) begin
            for (int c = 0; c < 4; c++) exp_lat[c] = exp_in[c];
            exp_gnd = 1'b0;
        end
    endtask

    task automatic ld_rise();
        ld_n = 1'b1;
        wait_n(6);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin exp_in[c] = '0; exp_lat[c] = '0; end
        exp_gnd = 1'b1;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(4);
        // R1 reset state
        check_codes("R1 reset code");
        chk("R1 reset mode", 64'(mode_o), 64'(exp_mode()));

        // R2 R4 R7: full writes per channel, latches hold while load high
        for (int c = 0; c < 4; c++) begin
            bus_wr(c, 1'b0, 1'b1, 14'(14'h0123 + c * 14'h0A51), 1'b1);
            check_codes("R7 hold while load high");
        end
        ld_fall();
        check_codes("R8 R2 R4 transfer all");
        chk("R12 mode after load", 64'(mode_o), 64'(exp_mode()));
        ld_rise();

        // R3 byte-shift sweep: low byte then upper field
        for (int c = 0; c < 4; c++) begin
            bus_wr(c, 1'b0, 1'b1, 14'(8'h3C + c * 17), 1'b1);
            bus_wr(c, 1'b0, 1'b0, 14'h3FC0 | 14'(c * 9 + 5), 1'b1);
        end
        ld_fall();
        check_codes("R3 byte shift upper field");
        ld_rise();

        // R5 broadcast ignores addr
        bus_wr(2, 1'b1, 1'b1, 14'h2A5C, 1'b1);
        ld_fall();
        check_codes("R5 broadcast");
        ld_rise();

        // R6 strobe without select changes nothing
        bus_wr(1, 1'b1, 1'b1, 14'h1111, 1'b0);
        ld_fall();
        check_codes("R6 no select no write");

        // R9 write-through with load held low
        for (int c = 0; c < 4; c++) begin
            bus_wr(c, 1'b0, 1'b1, 14'(14'h0777 * (c + 1)), 1'b1);
            check_codes("R9 write-through addressed only");
        end
        bus_wr(0, 1'b1, 1'b1, 14'h1E1E, 1'b1);
        check_codes("R9 write-through broadcast");
        ld_rise();

        // R10 asynchronous clear
        @(negedge clk);
        #1 clr_n = 1'b0;
        #1 chk("R10 clear immediate", 64'(mode_o), 64'h55 & 64'h0F | 64'hA0);
        exp_gnd = 1'b1;
        wait_n(4);

        // R11 load ignored while clear low
        bus_wr(3, 1'b0, 1'b1, 14'h0BCD, 1'b1);
        ld_fall();
        check_codes("R11 load ignored under clear");
        bus_wr(1, 1'b0, 1'b1, 14'h0321, 1'b1);
        check_codes("R11 write-through ignored under clear");
        ld_rise();

        // R12 ground held after release until next load fall
        clr_n = 1'b1;
        wait_n(8);
        chk("R12 ground held", 64'(mode_o), 64'(exp_mode()));
        check_codes("R12 codes held");
        ld_fall();
        chk("R12 drive after load", 64'(mode_o), 64'(exp_mode()));
        check_codes("R12 codes loaded");
        ld_rise();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule